// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two equal-width buses, called A and B, and moves data between them in either direction. Each direction owns a storage register with a capture clock of its own: the A-to-B register samples the A-side input, and the B-to-A register samples the B-side input. An active-low output enable and a direction input pick which side, if either, is driven. For each direction a select input picks whether the driven side sees the live data from the opposite side or the value held in that direction's register.

The tri-state pads are split into an input vector, an output data vector and an output-enable vector per side. This keeps the block synthesizable and lets a bench observe every decision at the ports. Both registers keep capturing whatever the output state is. Data can therefore be parked while the buses are isolated and sent out later. Outputs are combinational from the registers, the live inputs and the control inputs, so no cycles of latency are added.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A high `rst` sampled on a rising edge of `clk_ab` clears the A-to-B register to zero. A high `rst` sampled on a rising edge of `clk_ba` clears the B-to-A register to zero. Each register is cleared only by its own clock.
- R2: On a rising edge of `clk_ab` with `rst` low, the A-to-B register loads `a_in`. The B-to-A register does not change.
- R3: On a rising edge of `clk_ba` with `rst` low, the B-to-A register loads `b_in`. The A-to-B register does not change.
- R4: With `oe_n` = 0 and `dir` = 1, `b_oe` is all ones and `a_oe` is all zeros.
- R5: With `oe_n` = 0 and `dir` = 0, `a_oe` is all ones and `b_oe` is all zeros.
- R6: While B is driven, `b_out` equals the live `a_in` when `sel_ab` = 0. It equals the A-to-B register when `sel_ab` = 1.
- R7: While A is driven, `a_out` equals the live `b_in` when `sel_ba` = 0. It equals the B-to-A register when `sel_ba` = 1.
- R8: With `oe_n` = 1, both `a_oe` and `b_oe` are all zeros and both output data vectors are zero.
- R9: Both registers capture on their clocks while `oe_n` = 1, and the stored values can be sent out once the outputs are enabled.
- R10: `a_oe` and `b_oe` are never both non-zero. Each is always either all ones or all zeros.
- R11: The output data vector of a side that is not driven is zero.
- R12: While one side is driven, either register or both can still be loaded, whatever the value of `dir`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-to-B register (rising edge) |
| clk_ba | input | 1 | Capture clock of the B-to-A register (rising edge) |
| rst | input | 1 | Synchronous active-high clear, sampled by each capture clock |
| oe_n | input | 1 | Active-low output enable; high isolates both sides |
| dir | input | 1 | 1 drives B from the A side, 0 drives A from the B side |
| sel_ab | input | 1 | B-side source: 0 live `a_in`, 1 A-to-B register |
| sel_ba | input | 1 | A-side source: 0 live `b_in`, 1 B-to-A register |
| a_in | input | WIDTH | Data seen on the A side |
| b_in | input | WIDTH | Data seen on the B side |
| a_out | output | WIDTH | Data driven onto the A side |
| a_oe | output | WIDTH | A-side pad enables, all ones when driving |
| b_out | output | WIDTH | Data driven onto the B side |
| b_oe | output | WIDTH | B-side pad enables, all ones when driving |

## Verification
The bench builds the block with the default WIDTH of 8. At that width, patterns such as 0x5A, 0xA5 and 0xC3 separate every bit of the live path from the stored path, and the all-ones or all-zeros rule on the enable vectors can be checked over all eight pad enables. The capture clocks are pulsed one at a time and together. This exposes any crossing between the two registers, and resets that arrive on only one of the clocks.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Which side of the transceiver is currently driven
    typedef enum logic [1:0] {
        DRIVE_NONE = 2'd0,
        DRIVE_TO_B = 2'd1,
        DRIVE_TO_A = 2'd2
    } drive_e;

    // Index of each direction in the per-direction arrays
    localparam int DIR_AB = 0;
    localparam int DIR_BA = 1;
    localparam int NUM_DIRS = 2;

endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } store_t;

    store_t store_d;
    store_t store_q;

    always_comb begin
        store_d = store_q;
        store_d.data = din;
        if (rst) begin
            store_d.data = '0;
        end
    end

    always_ff @(posedge clk) begin
        store_q <= store_d;
    end

    assign dout = store_q.data;

endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
    import xcvr_pkg::*;
(
    input  logic   oe_n,
    input  logic   dir,
    output drive_e mode
);

    always_comb begin
        if (oe_n) begin
            mode = DRIVE_NONE;
        end else if (dir) begin
            mode = DRIVE_TO_B;
        end else begin
            mode = DRIVE_TO_A;
        end
    end

endmodule

// File: rtl/xcvr_out_side.sv
module xcvr_out_side #(
    parameter int WIDTH = 8
) (
    input  logic             enable,
    input  logic             use_stored,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] pad_oe
);

    logic [WIDTH-1:0] picked;

    always_comb begin
        picked = use_stored ? stored : live;
        data   = enable ? picked : '0;
        pad_oe = {WIDTH{enable}};
    end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe
);

    drive_e mode;

    logic [NUM_DIRS-1:0]            cap_clk;
    logic [NUM_DIRS-1:0]            side_en;
    logic [NUM_DIRS-1:0]            side_sel;
    logic [NUM_DIRS-1:0][WIDTH-1:0] cap_din;
    logic [NUM_DIRS-1:0][WIDTH-1:0] cap_q;
    logic [NUM_DIRS-1:0][WIDTH-1:0] live_src;
    logic [NUM_DIRS-1:0][WIDTH-1:0] side_data;
    logic [NUM_DIRS-1:0][WIDTH-1:0] side_oe;
    logic [WIDTH-1:0]               stored_ab;
    logic [WIDTH-1:0]               stored_ba;

    xcvr_drive_ctl u_ctl (
        .oe_n (oe_n),
        .dir  (dir),
        .mode (mode)
    );

    // Direction AB: captures A, feeds the B side. Direction BA: the reverse.
    always_comb begin
        cap_clk[DIR_AB]  = clk_ab;
        cap_clk[DIR_BA]  = clk_ba;
        cap_din[DIR_AB]  = a_in;
        cap_din[DIR_BA]  = b_in;
        live_src[DIR_AB] = a_in;
        live_src[DIR_BA] = b_in;
        side_sel[DIR_AB] = sel_ab;
        side_sel[DIR_BA] = sel_ba;
        side_en[DIR_AB]  = (mode == DRIVE_TO_B);
        side_en[DIR_BA]  = (mode == DRIVE_TO_A);
    end

    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_dir
        xcvr_store_reg #(.WIDTH(WIDTH)) u_store (
            .clk  (cap_clk[g]),
            .rst  (rst),
            .din  (cap_din[g]),
            .dout (cap_q[g])
        );

        xcvr_out_side #(.WIDTH(WIDTH)) u_out (
            .enable     (side_en[g]),
            .use_stored (side_sel[g]),
            .live       (live_src[g]),
            .stored     (cap_q[g]),
            .data       (side_data[g]),
            .pad_oe     (side_oe[g])
        );
    end

    assign stored_ab = cap_q[DIR_AB];
    assign stored_ba = cap_q[DIR_BA];

    assign b_out = side_data[DIR_AB];
    assign b_oe  = side_oe[DIR_AB];
    assign a_out = side_data[DIR_BA];
    assign a_oe  = side_oe[DIR_BA];

endmodule

module bus_xcvr_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk_ab,
    input logic             clk_ba,
    input logic             rst,
    input logic             oe_n,
    input logic             dir,
    input logic             sel_ab,
    input logic             sel_ba,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] a_oe,
    input logic [WIDTH-1:0] b_out,
    input logic [WIDTH-1:0] b_oe,
    input logic [WIDTH-1:0] stored_ab,
    input logic [WIDTH-1:0] stored_ba
);

    logic             seen_ab = 1'b0;
    logic             seen_ba = 1'b0;
    logic             rst_prev_ab = 1'b0;
    logic             rst_prev_ba = 1'b0;
    logic [WIDTH-1:0] a_prev = '0;
    logic [WIDTH-1:0] b_prev = '0;

    always_ff @(posedge clk_ab) begin
        seen_ab     <= 1'b1;
        rst_prev_ab <= rst;
        a_prev      <= a_in;
    end

    always_ff @(posedge clk_ba) begin
        seen_ba     <= 1'b1;
        rst_prev_ba <= rst;
        b_prev      <= b_in;
    end

    p_clear_ab_r1: assert property (@(posedge clk_ab) disable iff (rst)
        (seen_ab && rst_prev_ab) |-> (stored_ab == '0));

    p_clear_ba_r1: assert property (@(posedge clk_ba) disable iff (rst)
        (seen_ba && rst_prev_ba) |-> (stored_ba == '0));

    p_load_ab_r2: assert property (@(posedge clk_ab) disable iff (rst)
        (seen_ab && !rst_prev_ab) |-> (stored_ab == a_prev));

    p_load_ba_r3: assert property (@(posedge clk_ba) disable iff (rst)
        (seen_ba && !rst_prev_ba) |-> (stored_ba == b_prev));

    p_drive_b_r4: assert property (@(posedge clk_ab) disable iff (rst)
        (!oe_n && dir) |-> (&b_oe && a_oe == '0));

    p_drive_a_r5: assert property (@(posedge clk_ba) disable iff (rst)
        (!oe_n && !dir) |-> (&a_oe && b_oe == '0));

    p_live_b_r6: assert property (@(posedge clk_ab) disable iff (rst)
        (!oe_n && dir && !sel_ab) |-> (b_out == a_in));

    p_live_a_r7: assert property (@(posedge clk_ba) disable iff (rst)
        (!oe_n && !dir && !sel_ba) |-> (a_out == b_in));

    p_isolate_r8: assert property (@(posedge clk_ab) disable iff (rst)
        oe_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

    p_exclusive_r10: assert property (@(posedge clk_ab) disable iff (rst)
        !((|a_oe) && (|b_oe)));

    p_whole_vec_r10: assert property (@(posedge clk_ba) disable iff (rst)
        ((a_oe == '0) || (&a_oe)) && ((b_oe == '0) || (&b_oe)));

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_ab    (clk_ab),
    .clk_ba    (clk_ba),
    .rst       (rst),
    .oe_n      (oe_n),
    .dir       (dir),
    .sel_ab    (sel_ab),
    .sel_ba    (sel_ba),
    .a_in      (a_in),
    .b_in      (b_in),
    .a_out     (a_out),
    .a_oe      (a_oe),
    .b_out     (b_out),
    .b_oe      (b_oe),
    .stored_ab (stored_ab),
    .stored_ba (stored_ba)
);

// File: tb/bus_xcvr_reg_test.sv
module bus_xcvr_reg_test;

    localparam int W = 8;

    typedef struct {
        string        req;
        logic [W-1:0] a_out;
        logic [W-1:0] a_oe;
        logic [W-1:0] b_out;
        logic [W-1:0] b_oe;
    } expect_t;

    logic         clk = 1'b0;
    logic         clk_ab = 1'b0;
    logic         clk_ba = 1'b0;
    logic         rst = 1'b0;
    logic         oe_n = 1'b1;
    logic         dir = 1'b0;
    logic         sel_ab = 1'b0;
    logic         sel_ba = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out;
    logic [W-1:0] a_oe;
    logic [W-1:0] b_out;
    logic [W-1:0] b_oe;

    expect_t      sb_q[$];
    logic [W-1:0] mdl_ab = '0;
    logic [W-1:0] mdl_ba = '0;
    int           n_vec = 0;
    int           n_bad = 0;
    bit           driver_done = 1'b0;

    always #5 clk = ~clk;

    bus_xcvr_reg #(.WIDTH(W)) uut (
        .clk_ab (clk_ab),
        .clk_ba (clk_ba),
        .rst    (rst),
        .oe_n   (oe_n),
        .dir    (dir),
        .sel_ab (sel_ab),
        .sel_ba (sel_ba),
        .a_in   (a_in),
        .b_in   (b_in),
        .a_out  (a_out),
        .a_oe   (a_oe),
        .b_out  (b_out),
        .b_oe   (b_oe)
    );

    // Driver: one vector per clk cycle; capture pulses land before the monitor samples.
    task automatic apply(input string req, input logic rs, input logic oen,
                         input logic d, input logic sab, input logic sba,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic cab, input logic cba);
        expect_t e;
        logic    drv_b;
        logic    drv_a;
        @(posedge clk);
        #1;
        rst = rs; oe_n = oen; dir = d; sel_ab = sab; sel_ba = sba;
        a_in = a; b_in = b;
        #1;
        clk_ab = cab;
        clk_ba = cba;
        if (cab) mdl_ab = rs ? '0 : a;
        if (cba) mdl_ba = rs ? '0 : b;
        #1;
        clk_ab = 1'b0;
        clk_ba = 1'b0;
        drv_b   = !oen && d;
        drv_a   = !oen && !d;
        e.req   = req;
        e.b_oe  = {W{drv_b}};
        e.a_oe  = {W{drv_a}};
        e.b_out = drv_b ? (sab ? mdl_ab : a) : '0;
        e.a_out = drv_a ? (sba ? mdl_ba : b) : '0;
        sb_q.push_back(e);
    endtask

    // Monitor: samples on the falling edge, away from every driven change.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                expect_t e;
                e = sb_q.pop_front();
                n_vec++;
                if (a_out !== e.a_out || a_oe !== e.a_oe ||
                    b_out !== e.b_out || b_oe !== e.b_oe) begin
                    n_bad++;
                    $display("FAIL %s: a_out=%h a_oe=%h b_out=%h b_oe=%h expected a_out=%h a_oe=%h b_out=%h b_oe=%h",
                             e.req, a_out, a_oe, b_out, b_oe,
                             e.a_out, e.a_oe, e.b_out, e.b_oe);
                end
                if ((|a_oe) && (|b_oe)) begin
                    n_bad++;
                    $display("FAIL R10: a_oe=%h b_oe=%h expected one side all zeros", a_oe, b_oe);
                end
            end
        end
    end

    initial begin
        // R1: clear both registers, then show the stored values on each side
        apply("R1 reset", 1, 1, 0, 0, 0, 8'hFF, 8'hEE, 1, 1);
        apply("R1 stored AB zero", 0, 0, 1, 1, 0, 8'h33, 8'h44, 0, 0);
        apply("R1 stored BA zero", 0, 0, 0, 0, 1, 8'h33, 8'h44, 0, 0);
        // R4 R6 R11: live A to B
        apply("R4 R6 R11 live to B", 0, 0, 1, 0, 0, 8'h5A, 8'h00, 0, 0);
        // R2: capture A, then read back stored over different live data
        apply("R2 capture A", 0, 0, 1, 0, 0, 8'hC3, 8'h00, 1, 0);
        apply("R2 R6 stored to B", 0, 0, 1, 1, 0, 8'h11, 8'h22, 0, 0);
        // R12: load B register while B is the driven side
        apply("R12 capture B while driving B", 0, 0, 1, 1, 0, 8'h11, 8'h7E, 0, 1);
        // R3 R5 R7: send stored B value to A
        apply("R3 R5 R7 stored to A", 0, 0, 0, 0, 1, 8'h66, 8'h99, 0, 0);
        apply("R7 R11 live to A", 0, 0, 0, 0, 0, 8'h66, 8'h99, 0, 0);
        // R8 R9: capture both while isolated
        apply("R8 R9 isolated capture", 0, 1, 1, 1, 1, 8'hA5, 8'h3C, 1, 1);
        apply("R8 isolated select low", 0, 1, 0, 0, 0, 8'hFF, 8'hFF, 0, 0);
        apply("R9 isolated AB value out", 0, 0, 1, 1, 0, 8'h00, 8'h00, 0, 0);
        apply("R9 isolated BA value out", 0, 0, 0, 0, 1, 8'h00, 8'h00, 0, 0);
        // R2 independence: only the AB clock pulses, BA keeps 3C
        apply("R2 AB only capture", 0, 0, 0, 0, 1, 8'h01, 8'h02, 1, 0);
        apply("R2 AB took 01", 0, 0, 1, 1, 0, 8'hF0, 8'h0F, 0, 0);
        // R3 independence: only the BA clock pulses
        apply("R3 BA only capture", 0, 0, 1, 1, 0, 8'h80, 8'h40, 0, 1);
        apply("R3 BA took 40", 0, 0, 0, 0, 1, 8'h80, 8'h08, 0, 0);
        // R1: reset seen by clk_ab only leaves BA untouched
        apply("R1 reset on AB clock only", 1, 1, 0, 0, 0, 8'h77, 8'h77, 1, 0);
        apply("R1 AB cleared", 0, 0, 1, 1, 0, 8'h55, 8'h55, 0, 0);
        apply("R1 BA kept", 0, 0, 0, 0, 1, 8'h55, 8'h55, 0, 0);
        // R10 R12: both clocks with A driven, then flip direction
        apply("R10 R12 capture both while driving A", 0, 0, 0, 1, 1, 8'h9C, 8'hC9, 1, 1);
        apply("R10 R12 flipped to B", 0, 0, 1, 1, 1, 8'h00, 8'h00, 0, 0);
        repeat (3) @(posedge clk);
        driver_done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (driver_done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule